// File: doc/BRIEF.md
# Power Switchover Time Stamp

This block records the calendar time at the moment a system moves between its main supply and its backup battery. A calendar feeds it the current seconds, minutes, hours, date and month every cycle. A power-state input is brought into the clock domain and edge-detected. Each direction of switchover has its own five-byte snapshot set, and the read port exposes both sets at fixed byte addresses.

Each snapshot set is armed while it is empty. The first switchover in its direction fills it. Later switchovers in the same direction leave it alone until a clear strobe empties both sets. The five fields of a set are written on one clock edge, so a snapshot never mixes fields from two different seconds.

Top module: `supply_switch_stamp`

## Requirements
- R1: After reset, every byte at read addresses 16h through 1Fh reads 0.
- R2: A change of `on_batt_i` from 0 (main) to 1 (battery) fills the to-battery set. Seconds, minutes, hours, date and month read at 16h, 17h, 18h, 19h and 1Ah in that order.
- R3: A change of `on_batt_i` from 1 to 0 fills the to-main set. The same five fields read at 1Bh through 1Fh in the same order, and the to-battery set is unchanged.
- R4: Once a set holds a snapshot, later switchovers in its direction do not alter it.
- R5: A one-cycle pulse on `clr_i` zeroes both sets and re-arms them, so the next switchover in each direction captures again.
- R6: If `clr_i` is high on the same edge that would capture, the clear wins and that capture is lost. The set reads 0 afterwards.
- R7: A capture takes all five fields from the calendar inputs present on the single edge `SYNC_STAGES`+1 cycles after `on_batt_i` changes.
- R8: Read addresses outside 16h–1Fh return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| on_batt_i | input | 1 | Power state, 1 = running from battery, asynchronous |
| sec_i | input | 8 | Current seconds from calendar |
| min_i | input | 8 | Current minutes from calendar |
| hour_i | input | 8 | Current hours from calendar |
| date_i | input | 8 | Current day of month from calendar |
| month_i | input | 8 | Current month from calendar |
| clr_i | input | 1 | Clear strobe for both snapshot sets, one cycle |
| rd_addr_i | input | 8 | Byte read address |
| rd_data_o | output | 8 | Byte read data, combinational from address |

## Verification
On every cycle, the assertions check four things. A set only becomes valid after a detected edge in its direction. A valid set never changes except through a clear. An empty set reads as zeros. A newly valid set equals the calendar value sampled on its capture edge, which shows that all five bytes are latched together. Out-of-range reads returning zero is also checked on every cycle. Only the bench scenarios can show the end-to-end behaviour as seen at the read port: the latency from the power-state change to capture, the mapping of fields to addresses, first-event stickiness across repeated switchovers, and a capture lost to a coincident clear.

// File: rtl/sws_pkg.sv
package sws_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned NFIELDS = 5;

  typedef struct packed {
    logic [DW-1:0] month;
    logic [DW-1:0] date;
    logic [DW-1:0] hour;
    logic [DW-1:0] min;
    logic [DW-1:0] sec;
  } stamp_t;

  typedef enum logic {SET_TO_BATT = 1'b0, SET_TO_MAIN = 1'b1} set_e;
endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sws_edge.sv
module sws_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic to_batt_o,
  output logic to_main_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign to_batt_o = lvl_i & ~prev_q;
  assign to_main_o = ~lvl_i & prev_q;
endmodule

// File: rtl/sws_bank.sv
module sws_bank
  import sws_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   cap_i,
  input  stamp_t now_i,
  output stamp_t stamp_o,
  output logic   vld_o
);
  stamp_t stamp_q;
  logic   vld_q;

  // clear beats capture; capture only while empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_q <= '0;
      vld_q   <= 1'b0;
    end else if (clr_i) begin
      stamp_q <= '0;
      vld_q   <= 1'b0;
    end else if (cap_i && !vld_q) begin
      stamp_q <= now_i;
      vld_q   <= 1'b1;
    end
  end

  assign stamp_o = stamp_q;
  assign vld_o   = vld_q;
endmodule

// File: rtl/sws_rdmux.sv
module sws_rdmux
  import sws_pkg::*;
#(
  parameter int unsigned         ADDR_W  = 8,
  parameter logic [ADDR_W-1:0]   BASE_TB = 8'h16,
  parameter logic [ADDR_W-1:0]   BASE_TM = 8'h1B
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  stamp_t            set_i [2],
  output logic [DW-1:0]     data_o
);
  localparam logic [ADDR_W-1:0] NF = ADDR_W'(NFIELDS);

  function automatic logic [DW-1:0] pick(input stamp_t s, input logic [ADDR_W-1:0] off);
    logic [DW-1:0] r;
    r = '0;
    for (int k = 0; k < NFIELDS; k++)
      if (off == ADDR_W'(k)) r = s[k*DW +: DW];
    return r;
  endfunction

  logic [ADDR_W-1:0] off_tb, off_tm;

  always_comb begin
    off_tb = addr_i - BASE_TB;
    off_tm = addr_i - BASE_TM;
    data_o = '0;
    if (addr_i >= BASE_TB && off_tb < NF) data_o = pick(set_i[SET_TO_BATT], off_tb);
    if (addr_i >= BASE_TM && off_tm < NF) data_o = pick(set_i[SET_TO_MAIN], off_tm);
  end
endmodule

// File: rtl/supply_switch_stamp.sv
module supply_switch_stamp
  import sws_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_TB     = 8'h16,
  parameter logic [ADDR_W-1:0] BASE_TM     = 8'h1B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              on_batt_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic [7:0]        date_i,
  input  logic [7:0]        month_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic   batt_s;
  logic   edge_to_batt, edge_to_main;
  logic   set_vld [2];
  stamp_t set_q   [2];
  stamp_t now_t;

  assign now_t = '{month: month_i, date: date_i, hour: hour_i, min: min_i, sec: sec_i};

  sws_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(on_batt_i), .q_o(batt_s)
  );

  sws_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(batt_s),
    .to_batt_o(edge_to_batt), .to_main_o(edge_to_main)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_set
      sws_bank u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_i),
        .cap_i  ((g == int'(SET_TO_MAIN)) ? edge_to_main : edge_to_batt),
        .now_i  (now_t),
        .stamp_o(set_q[g]),
        .vld_o  (set_vld[g])
      );
    end
  endgenerate

  sws_rdmux #(.ADDR_W(ADDR_W), .BASE_TB(BASE_TB), .BASE_TM(BASE_TM)) u_rdmux (
    .addr_i(rd_addr_i), .set_i(set_q), .data_o(rd_data_o)
  );
endmodule

// File: rtl/sws_chk.sv
module sws_chk
  import sws_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] BASE_TB = 8'h16,
  parameter logic [ADDR_W-1:0] BASE_TM = 8'h1B
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o,
  input logic              to_batt,
  input logic              to_main,
  input logic              vld_tb,
  input logic              vld_tm,
  input stamp_t            st_tb,
  input stamp_t            st_tm,
  input stamp_t            now_t
);
  localparam logic [ADDR_W-1:0] TOP = BASE_TM + ADDR_W'(NFIELDS) - 1'b1;

  AST_TB_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_tb) |-> $past(to_batt)); // R2
  AST_TM_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_tm) |-> $past(to_main)); // R3
  AST_TB_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_tb && !clr_i) |=> (vld_tb && $stable(st_tb))); // R4
  AST_TM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_tm && !clr_i) |=> (vld_tm && $stable(st_tm))); // R4
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!vld_tb && !vld_tm && st_tb == '0 && st_tm == '0)); // R6
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_tb |-> st_tb == '0) and (!vld_tm |-> st_tm == '0)); // R5
  AST_TB_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_tb) |-> st_tb == $past(now_t)); // R7
  AST_TM_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_tm) |-> st_tm == $past(now_t)); // R7
  AST_OOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i < BASE_TB || rd_addr_i > TOP) |-> rd_data_o == 8'h00); // R8
endmodule

bind supply_switch_stamp sws_chk #(.ADDR_W(ADDR_W), .BASE_TB(BASE_TB), .BASE_TM(BASE_TM)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .to_batt(edge_to_batt), .to_main(edge_to_main),
  .vld_tb(set_vld[0]), .vld_tm(set_vld[1]),
  .st_tb(set_q[0]), .st_tm(set_q[1]), .now_t(now_t)
);

// File: tb/supply_switch_stamp_bench.sv
module supply_switch_stamp_bench;
  localparam int SYNC = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       on_batt_i = 1'b0;
  logic [7:0] sec_i = '0, min_i = '0, hour_i = '0, date_i = '0, month_i = '0;
  logic       clr_i = 1'b0;
  logic [7:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [39:0] exp_tb = '0, exp_tm = '0;
  bit vld_tb = 0, vld_tm = 0;

  always #2 clk_i = ~clk_i;

  supply_switch_stamp #(.SYNC_STAGES(SYNC)) u_supply_switch_stamp (.*);

  // {clear first, target battery state, month,date,hour,min,sec}
  localparam logic [41:0] VEC [6] = '{
    {1'b0, 1'b1, 40'h03_14_09_26_53},  // R2
    {1'b0, 1'b0, 40'h03_14_11_02_07},  // R3
    {1'b0, 1'b1, 40'h05_01_00_00_01},  // R4
    {1'b0, 1'b0, 40'h05_01_00_10_44},  // R4
    {1'b1, 1'b1, 40'h12_31_23_59_58},  // R5
    {1'b0, 1'b0, 40'h01_01_00_00_00}   // R5
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, rd_addr_i, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    rd_addr_i = a;
    #1 check(tag, rd_data_o, exp);
  endtask

  task automatic rd_all(input string tag);
    for (int k = 0; k < 5; k++) begin
      rd(8'h16 + 8'(k), exp_tb[k*8 +: 8], tag);
      rd(8'h1B + 8'(k), exp_tm[k*8 +: 8], tag);
    end
  endtask

  task automatic set_time(input logic [39:0] t);
    {month_i, date_i, hour_i, min_i, sec_i} = t;
  endtask

  task automatic pulse_clr();
    @(negedge clk_i) clr_i = 1'b1;
    @(negedge clk_i) clr_i = 1'b0;
    exp_tb = '0; exp_tm = '0; vld_tb = 0; vld_tm = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd_all("R1 reset");

    for (int i = 0; i < 6; i++) begin
      if (VEC[i][41]) begin
        pulse_clr();
        rd(8'h1B, 8'h00, "R5 cleared");
      end
      @(negedge clk_i);
      set_time(VEC[i][39:0]);
      on_batt_i = VEC[i][40];
      if (VEC[i][40] && !vld_tb) begin exp_tb = VEC[i][39:0]; vld_tb = 1; end
      if (!VEC[i][40] && !vld_tm) begin exp_tm = VEC[i][39:0]; vld_tm = 1; end
      repeat (SYNC + 3) @(negedge clk_i);
      rd_all($sformatf("R2/R3/R4/R5 vec%0d", i));
      rd(8'h15, 8'h00, "R8 below");
      rd(8'h20, 8'h00, "R8 above");
      rd(8'hFF, 8'h00, "R8 far");
    end

    // R7: calendar changes every cycle; fields carry distinct offsets
    pulse_clr();
    begin
      logic [7:0] c0 = 8'h40;
      @(negedge clk_i);
      on_batt_i = 1'b1;
      for (int s = 0; s < 8; s++) begin
        set_time({c0 + 8'(s) + 8'd4, c0 + 8'(s) + 8'd3, c0 + 8'(s) + 8'd2,
                  c0 + 8'(s) + 8'd1, c0 + 8'(s)});
        @(negedge clk_i);
      end
      exp_tb = {c0 + 8'(SYNC) + 8'd4, c0 + 8'(SYNC) + 8'd3, c0 + 8'(SYNC) + 8'd2,
                c0 + 8'(SYNC) + 8'd1, c0 + 8'(SYNC)};
      vld_tb = 1;
      rd_all("R7 latency");
    end

    // R6: clear on the capture edge drops the capture
    pulse_clr();
    set_time(40'h07_04_12_00_30);
    @(negedge clk_i) on_batt_i = 1'b0;
    for (int s = 0; s < SYNC; s++) @(negedge clk_i);
    clr_i = 1'b1;
    @(negedge clk_i) clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rd_all("R6 clear wins");
    // set re-armed: next switchover captures
    set_time(40'h07_04_12_05_00);
    @(negedge clk_i) on_batt_i = 1'b1;
    repeat (SYNC + 3) @(negedge clk_i);
    @(negedge clk_i) on_batt_i = 1'b0;
    exp_tb = 40'h07_04_12_05_00;
    exp_tm = 40'h07_04_12_05_00;
    repeat (SYNC + 3) @(negedge clk_i);
    rd_all("R6 rearm");

    finish_run();
  end
endmodule